// File: doc/BRIEF.md
# Commit-Gated Speculative Store Queue

This block holds stores from a speculative execution pipeline until the pipeline declares them final. Every accepted store takes one entry: a target address, write data and a 2-bit access-size code. New entries start out uncommitted. A commit pulse marks all entries accepted before that cycle as released. Released entries then leave for memory one at a time, oldest first, through a valid/ready write port. A rollback pulse removes every entry that is still uncommitted in a single cycle. Released entries are kept and continue to drain.

The commit and rollback inputs are meant to be the same strobes that checkpoint and restore the pipeline's shadowed register state. Memory side effects therefore follow the same boundary as the architectural registers. The pipeline sees back-pressure through `st_ready_o`. A store that is offered while the queue is full is held off, not discarded, and the pipeline keeps offering it until it is taken.

Top module: `spec_store_queue`

## Requirements
- R1: While reset is asserted and right after it, `empty_o`=1, `full_o`=0, `mem_valid_o`=0 and `st_ready_o`=1.
- R2: A store is accepted when `st_valid_i` and `st_ready_o` are both high at a rising clock edge. An accepted store that is not yet committed never appears on the memory port.
- R3: A `commit_i` pulse releases every entry accepted before that cycle. A store accepted in the same cycle as the commit stays uncommitted.
- R4: Released entries leave in acceptance order, with address, data and size unchanged. One entry retires per cycle in which `mem_valid_o` and `mem_ready_i` are both high. While `mem_ready_i` is low, `mem_valid_o` stays high and the payload stays stable.
- R5: A `rollback_i` pulse without `commit_i` removes all uncommitted entries by the next cycle. Released entries are unaffected.
- R6: While `rollback_i` is high, `st_ready_o` is low and no store is accepted.
- R7: When `commit_i` and `rollback_i` are high in the same cycle, the commit takes effect and the rollback has no effect.
- R8: `full_o` is 1 exactly when all DEPTH entries (released or not) are occupied. While full, `st_ready_o` is 0. A stalled store is accepted once space frees.
- R9: `empty_o` is 1 exactly when no entry, released or uncommitted, is held.
- R10: Order and contents are preserved across long mixed sequences of stores, commits, rollbacks and memory stalls that wrap the storage many times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Pipeline offers a store |
| st_ready_o | output | 1 | Queue can take the store this cycle |
| st_addr_i | input | ADDR_W | Store address |
| st_data_i | input | DATA_W | Store data |
| st_size_i | input | SIZE_W | Access-size code, carried unchanged |
| commit_i | input | 1 | Release all entries accepted before this cycle |
| rollback_i | input | 1 | Discard all uncommitted entries |
| mem_valid_o | output | 1 | Oldest released entry is presented |
| mem_ready_i | input | 1 | Memory takes the presented entry |
| mem_addr_o | output | ADDR_W | Address of presented entry |
| mem_data_o | output | DATA_W | Data of presented entry |
| mem_size_o | output | SIZE_W | Size code of presented entry |
| full_o | output | 1 | All entries occupied |
| empty_o | output | 1 | No entries held |

## Verification
A misplaced commit or tail pointer shows up quickly at the ports. Either `mem_valid_o` rises one cycle after a commit that should not have released a store, or it stays low when it should have risen. The same fault also moves the cycle at which `full_o` or `empty_o` changes. A rollback that rewinds to the wrong place changes the occupancy, and `st_ready_o` or `full_o` differs within a cycle or two. A lost or reordered entry appears as a wrong payload at the next memory handshake. For that reason the bench compares every output on every cycle against a queue-based model of released and uncommitted stores.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
  localparam int unsigned SSQ_DEPTH  = 8;
  localparam int unsigned SSQ_ADDR_W = 32;
  localparam int unsigned SSQ_DATA_W = 32;
  localparam int unsigned SSQ_SIZE_W = 2;

  typedef enum logic [1:0] {
    TAIL_HOLD   = 2'd0,
    TAIL_PUSH   = 2'd1,
    TAIL_REWIND = 2'd2
  } tail_op_e;
endpackage

// File: rtl/ssq_ptr_ctrl.sv
module ssq_ptr_ctrl
  import ssq_pkg::*;
#(
  parameter int unsigned DEPTH = SSQ_DEPTH
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic                       pop_i,
  input  logic                       commit_i,
  input  logic                       rollback_i,
  output logic [$clog2(DEPTH)-1:0]   head_idx_o,
  output logic [$clog2(DEPTH)-1:0]   tail_idx_o,
  output logic                       full_o,
  output logic                       empty_o,
  output logic                       released_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned PTR_W = IDX_W + 1;

  logic [PTR_W-1:0] head_q, cmt_q, tail_q;
  logic [PTR_W-1:0] head_d, cmt_d, tail_d;
  logic [PTR_W-1:0] occ, rel_cnt;
  tail_op_e         tail_op;

  assign occ     = tail_q - head_q;
  assign rel_cnt = cmt_q - head_q;

  // commit has priority; pushes are already blocked during rollback
  always_comb begin
    if (commit_i)        tail_op = push_i ? TAIL_PUSH : TAIL_HOLD;
    else if (rollback_i) tail_op = TAIL_REWIND;
    else                 tail_op = push_i ? TAIL_PUSH : TAIL_HOLD;
  end

  always_comb begin
    unique case (tail_op)
      TAIL_PUSH:   tail_d = tail_q + PTR_W'(1);
      TAIL_REWIND: tail_d = cmt_q;
      default:     tail_d = tail_q;
    endcase
    cmt_d  = commit_i ? tail_q : cmt_q;
    head_d = pop_i ? head_q + PTR_W'(1) : head_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      cmt_q  <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      cmt_q  <= cmt_d;
      tail_q <= tail_d;
    end
  end

  assign head_idx_o = head_q[IDX_W-1:0];
  assign tail_idx_o = tail_q[IDX_W-1:0];
  assign full_o     = (occ == PTR_W'(DEPTH));
  assign empty_o    = (head_q == tail_q);
  assign released_o = (head_q != cmt_q);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= PTR_W'(DEPTH)); // R8
  AST_PUSH_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i); // R8
  AST_CMT_INSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_cnt <= occ); // R5
  AST_COMMIT_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> cmt_q == $past(tail_q)); // R3
  AST_ROLLBACK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rollback_i && !commit_i) |=> tail_q == $past(cmt_q)); // R5
  AST_COMMIT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rollback_i && commit_i) |=> tail_q == $past(tail_q)); // R7
endmodule

// File: rtl/ssq_storage.sv
module ssq_storage #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 66
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] widx_i,
  input  logic [WIDTH-1:0]         wdata_i,
  input  logic [$clog2(DEPTH)-1:0] ridx_i,
  output logic [WIDTH-1:0]         rdata_o
);
  logic [WIDTH-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  slot_q[g] <= '0;
      else if (we_i && (widx_i == ($clog2(DEPTH))'(g))) slot_q[g] <= wdata_i;
    end
  end

  assign rdata_o = slot_q[ridx_i];
endmodule

// File: rtl/spec_store_queue.sv
module spec_store_queue
  import ssq_pkg::*;
#(
  parameter int unsigned DEPTH  = SSQ_DEPTH,
  parameter int unsigned ADDR_W = SSQ_ADDR_W,
  parameter int unsigned DATA_W = SSQ_DATA_W,
  parameter int unsigned SIZE_W = SSQ_SIZE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_valid_i,
  output logic              st_ready_o,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic [SIZE_W-1:0] st_size_i,
  input  logic              commit_i,
  input  logic              rollback_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic [SIZE_W-1:0] mem_size_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned ENT_W = ADDR_W + DATA_W + SIZE_W;

  logic             push, pop, released;
  logic [IDX_W-1:0] head_idx, tail_idx;
  logic [ENT_W-1:0] wr_ent, rd_ent;

  assign st_ready_o  = !full_o && !rollback_i;
  assign push        = st_valid_i && st_ready_o;
  assign mem_valid_o = released;
  assign pop         = mem_valid_o && mem_ready_i;
  assign wr_ent      = {st_addr_i, st_data_i, st_size_i};

  ssq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .pop_i      (pop),
    .commit_i   (commit_i),
    .rollback_i (rollback_i),
    .head_idx_o (head_idx),
    .tail_idx_o (tail_idx),
    .full_o     (full_o),
    .empty_o    (empty_o),
    .released_o (released)
  );

  ssq_storage #(.DEPTH(DEPTH), .WIDTH(ENT_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (push),
    .widx_i  (tail_idx),
    .wdata_i (wr_ent),
    .ridx_i  (head_idx),
    .rdata_o (rd_ent)
  );

  assign {mem_addr_o, mem_data_o, mem_size_o} = rd_ent;

  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o)
      && $stable(mem_data_o) && $stable(mem_size_o))); // R4
  AST_EMPTY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (!mem_valid_o && !full_o)); // R9
endmodule

// File: tb/spec_store_queue_tb_top.sv
module spec_store_queue_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int SW = 2;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [SW-1:0] s;
  } ent_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic st_valid_i = 1'b0, commit_i = 1'b0, rollback_i = 1'b0, mem_ready_i = 1'b0;
  logic [AW-1:0] st_addr_i = '0;
  logic [DW-1:0] st_data_i = '0;
  logic [SW-1:0] st_size_i = '0;
  logic st_ready_o, mem_valid_o, full_o, empty_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_data_o;
  logic [SW-1:0] mem_size_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  spec_store_queue #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW), .SIZE_W(SW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .st_valid_i(st_valid_i), .st_ready_o(st_ready_o),
    .st_addr_i(st_addr_i), .st_data_i(st_data_i), .st_size_i(st_size_i),
    .commit_i(commit_i), .rollback_i(rollback_i),
    .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i),
    .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o), .mem_size_o(mem_size_o),
    .full_o(full_o), .empty_o(empty_o)
  );

  int n_chk = 0, n_fail = 0, seq = 0, cyc_cnt = 0;
  bit done = 0, last_acc = 0;
  ent_t cq[$];
  ent_t uq[$];
  ent_t nxt;

  task automatic chk(string tag, string what, logic [79:0] act, logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic new_store();
    seq++;
    nxt.a = 32'h1000 + 32'(seq) * 4;
    nxt.d = $urandom;
    nxt.s = 2'(seq);
  endtask

  // one cycle: drive, compare every output against the model, advance the model
  task automatic cyc(bit sv, bit cm, bit rb, bit mr, string tag);
    bit er, ev;
    ent_t got;
    @(negedge clk_i);
    st_valid_i = sv; commit_i = cm; rollback_i = rb; mem_ready_i = mr;
    st_addr_i = nxt.a; st_data_i = nxt.d; st_size_i = nxt.s;
    #1;
    er = (cq.size() + uq.size() < DEPTH) && !rb;
    ev = cq.size() != 0;
    chk(tag, "st_ready", 80'(st_ready_o), 80'(er));
    chk(tag, "mem_valid", 80'(mem_valid_o), 80'(ev));
    if (ev) begin
      got = {mem_addr_o, mem_data_o, mem_size_o};
      chk("R4", "payload", 80'(got), 80'(cq[0]));
    end
    chk("R8", "full", 80'(full_o), 80'(cq.size() + uq.size() == DEPTH));
    chk("R9", "empty", 80'(empty_o), 80'(cq.size() + uq.size() == 0));
    @(posedge clk_i);
    if (ev && mr) void'(cq.pop_front());
    if (cm) begin
      foreach (uq[i]) cq.push_back(uq[i]);
      uq.delete();
    end else if (rb) begin
      uq.delete();
    end
    last_acc = sv && er;
    if (last_acc) begin
      uq.push_back(nxt);
      new_store();
    end
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cyc_cnt++;
      if (cyc_cnt > 100000 && !done) begin
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    new_store();
    repeat (2) @(negedge clk_i);
    chk("R1", "empty in reset", 80'(empty_o), 80'(1));
    chk("R1", "full in reset", 80'(full_o), 80'(0));
    chk("R1", "mem_valid in reset", 80'(mem_valid_o), 80'(0));
    chk("R1", "st_ready in reset", 80'(st_ready_o), 80'(1));
    rst_ni = 1'b1;
    cyc(0, 0, 0, 1, "R1");

    // uncommitted stores stay off the memory port
    repeat (3) cyc(1, 0, 0, 1, "R2");
    repeat (2) cyc(0, 0, 0, 1, "R2");

    // store in the commit cycle stays uncommitted
    cyc(1, 1, 0, 0, "R3");
    repeat (2) cyc(0, 0, 0, 0, "R3");
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, bit'(i % 2), "R4");
    cyc(0, 0, 1, 1, "R5");
    cyc(0, 0, 0, 1, "R5");

    // rollback keeps released entries, refuses a store offered with it
    repeat (2) cyc(1, 0, 0, 0, "R5");
    cyc(0, 1, 0, 0, "R5");
    repeat (2) cyc(1, 0, 0, 0, "R5");
    cyc(1, 0, 1, 0, "R6");
    chk("R6", "store refused during rollback", 80'(last_acc), 80'(0));
    cyc(0, 0, 0, 0, "R5");
    repeat (4) cyc(0, 0, 0, 1, "R5");

    // commit and rollback together: commit wins
    repeat (2) cyc(1, 0, 0, 0, "R7");
    cyc(1, 1, 1, 0, "R7");
    repeat (4) cyc(0, 0, 0, 1, "R7");

    // fill to full with memory stalled, hold an extra store
    for (int i = 0; i < DEPTH; i++) cyc(1, 0, 0, 0, "R8");
    repeat (3) cyc(1, 0, 0, 0, "R8");
    chk("R8", "stalled store not taken", 80'(last_acc), 80'(0));
    cyc(1, 1, 0, 0, "R8");
    for (int i = 0; i < 20 && !last_acc; i++) cyc(1, 0, 0, 1, "R8");
    chk("R8", "stalled store accepted later", 80'(last_acc), 80'(1));
    cyc(0, 1, 0, 1, "R8");
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, 1, "R9");

    // long mixed traffic wrapping the storage
    begin
      bit pend = 1;
      for (int i = 0; i < 3000; i++) begin
        bit cm, rb;
        cm = ($urandom % 6) == 0;
        rb = !cm && (($urandom % 9) == 0);
        cyc(pend, cm, rb, ($urandom % 3) != 0, "R10");
        if (last_acc) pend = ($urandom % 4) != 0;
        else if (!pend) pend = ($urandom % 2) == 0;
      end
    end
    cyc(0, 1, 0, 1, "R10");
    for (int i = 0; i < 30; i++) cyc(0, 0, 0, 1, "R10");
    chk("R9", "drained at end", 80'(empty_o), 80'(1));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule